// File: doc/BRIEF.md
# Pending Acknowledgement Completion Tracker

This block keeps count of the coherence messages still owed to one outstanding miss. When the transaction slot is opened, a signed counter starts at zero. Every accepted message carries a signed count field, and the tracker subtracts that field from the counter. A plain acknowledgement carries -1, so it moves the counter up by one. A data response or an echoed exclusive request carries the number of acknowledgements to expect, so it moves the counter down by that amount. The order in which these arrive does not matter.

The tracker checks the counter after every update, not only after data arrives. When an update leaves the counter at zero, the tracker posts a single completion trigger into a one-entry trigger queue, tagged with the line address captured when the slot was opened. The controller consumes the trigger on a later cycle.

The message input has no ready signal. A message is taken whenever the slot is open, and a message that arrives while the slot is closed is dropped. The trigger output follows valid/ready rules. Once raised, the valid stays high and the address stays stable until ready is sampled high with it. If a second completion is posted while the entry is still unconsumed, the tracker keeps one trigger and raises a sticky overrun flag.

Top module: `pend_ack_tracker`

## Requirements
- R1: After reset, the pending count is 0, the trigger valid is low and the overrun flag is low.
- R2: An allocate (when no deallocate is present) opens the slot, sets the pending count to 0 on the next edge and latches the line address. A message in that same cycle is not applied.
- R3: While the slot is open, and with neither allocate nor deallocate present, a message with valid high makes the next pending count equal to the old count minus the message's signed count field.
- R4: A message whose count field is -1 (all ones) raises the pending count by exactly one. After a message with field +k, exactly k such acknowledgements bring the count back to 0, and only the last of them posts the trigger.
- R5: When an applied message leaves the count at 0, the trigger valid is high after the next edge, and the trigger address equals the address latched at allocation. This includes a message with field 0 applied to a count of 0. A message that leaves a non-zero count posts no trigger.
- R6: A message with valid high while the slot is closed leaves the pending count unchanged and posts no trigger.
- R7: The trigger valid stays high, with a stable address, until ready is high at an edge. That edge clears it, unless a new trigger is posted in the same cycle.
- R8: If a trigger is posted while the trigger valid is high and ready is low, the overrun flag rises and stays high until deallocate. If ready is high in that same cycle, the overrun flag stays low and the trigger valid stays high.
- R9: A deallocate closes the slot and clears the pending count, the trigger valid and the overrun flag at the next edge. It has priority over an allocate or a message in the same cycle.
- R10: The pending count is CNT_W-bit two's complement and wraps modulo 2^CNT_W. For example, subtracting -128 from 0 gives -128 when CNT_W is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | Open the transaction slot |
| alloc_addr_i | input | ADDR_W | Line address captured at allocation |
| dealloc_i | input | 1 | Close the slot and clear all state |
| msg_valid_i | input | 1 | A message is present this cycle |
| msg_count_i | input | CNT_W | Signed count field carried by the message |
| trig_valid_o | output | 1 | A completion trigger is waiting |
| trig_ready_i | input | 1 | The consumer pops the trigger |
| trig_addr_o | output | ADDR_W | Line address carried by the trigger |
| pend_count_o | output | CNT_W | Signed pending count |
| overrun_o | output | 1 | Sticky: a trigger was posted over an unconsumed one |

## Verification
A wrong counter value shows on the pending count one edge after the message that caused it. The trigger then either appears when the counter did not reach zero, or stays missing when it did. A slot flag stuck open or closed shows on the next message as a count that changes or fails to change. A fault in the trigger entry shows as a valid that drops early, an address that drifts, or an overrun flag that disagrees with the pop timing one edge after the double post. Every field value of the small configuration is applied to a freshly opened slot, and acknowledgement chains of several lengths run to completion, so each of these faults reaches the ports within a few cycles.

// File: rtl/pat_pkg.sv
package pat_pkg;
  // Per-cycle command to the counter and trigger entry.
  typedef struct packed {
    logic clear;   // deallocate: wipe everything
    logic init;    // allocate: counter back to zero
    logic update;  // apply the message count field
  } slot_op_t;
endpackage

// File: rtl/pat_slot_ctrl.sv
module pat_slot_ctrl
  import pat_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              dealloc,
  input  logic              msg_valid,
  output logic              active,
  output logic [ADDR_W-1:0] line_addr,
  output slot_op_t          op
);
  // Deallocate outranks allocate, which outranks a message.
  always_comb begin
    op.clear  = dealloc;
    op.init   = alloc & ~dealloc;
    op.update = msg_valid & active & ~alloc & ~dealloc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      line_addr <= '0;
    end else if (op.clear) begin
      active    <= 1'b0;
    end else if (op.init) begin
      active    <= 1'b1;
      line_addr <= alloc_addr;
    end
  end
endmodule

// File: rtl/pat_ack_counter.sv
module pat_ack_counter
  import pat_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  slot_op_t                op,
  input  logic signed [CNT_W-1:0] delta,
  output logic signed [CNT_W-1:0] count,
  output logic                    done
);
  logic signed [CNT_W-1:0] next_val;

  // Subtraction wraps modulo 2^CNT_W.
  assign next_val = count - delta;
  // Completion is judged on the value after every applied update.
  assign done     = op.update && (next_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (op.clear || op.init) count <= '0;
    else if (op.update)          count <= next_val;
  end
endmodule

// File: rtl/pat_trigger_slot.sv
module pat_trigger_slot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              post,
  input  logic [ADDR_W-1:0] post_addr,
  input  logic              pop,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic              overrun
);
  logic popped;
  assign popped = valid & pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      addr    <= '0;
      overrun <= 1'b0;
    end else if (clear) begin
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else if (post) begin
      valid <= 1'b1;
      addr  <= post_addr;
      if (valid && !popped) overrun <= 1'b1;
    end else if (popped) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pend_ack_tracker.sv
module pend_ack_tracker
  import pat_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_i,
  input  logic [ADDR_W-1:0]       alloc_addr_i,
  input  logic                    dealloc_i,
  input  logic                    msg_valid_i,
  input  logic signed [CNT_W-1:0] msg_count_i,
  output logic                    trig_valid_o,
  input  logic                    trig_ready_i,
  output logic [ADDR_W-1:0]       trig_addr_o,
  output logic signed [CNT_W-1:0] pend_count_o,
  output logic                    overrun_o
);
  slot_op_t          op;
  logic              slot_active;
  logic [ADDR_W-1:0] line_addr;
  logic              done;

  pat_slot_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_i), .alloc_addr(alloc_addr_i),
    .dealloc(dealloc_i), .msg_valid(msg_valid_i),
    .active(slot_active), .line_addr(line_addr), .op(op)
  );

  pat_ack_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .op(op), .delta(msg_count_i),
    .count(pend_count_o), .done(done)
  );

  pat_trigger_slot #(.ADDR_W(ADDR_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .clear(op.clear), .post(done),
    .post_addr(line_addr), .pop(trig_ready_i),
    .valid(trig_valid_o), .addr(trig_addr_o), .overrun(overrun_o)
  );
endmodule

// File: rtl/pat_checker.sv
module pat_checker #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    alloc,
  input logic                    dealloc,
  input logic                    msg_valid,
  input logic signed [CNT_W-1:0] msg_count,
  input logic                    active,
  input logic signed [CNT_W-1:0] count,
  input logic                    trig_valid,
  input logic                    trig_ready,
  input logic [ADDR_W-1:0]       trig_addr,
  input logic                    overrun
);
  logic applied;
  assign applied = active & msg_valid & ~alloc & ~dealloc;

  a_r3_subtract: assert property (@(posedge clk) disable iff (!rst_n)
    applied |=> count == CNT_W'($past(count) - $past(msg_count)));

  a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (applied && CNT_W'(count - msg_count) == '0) |=> trig_valid);

  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !alloc && !dealloc) |=> $stable(count));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !trig_ready && !dealloc) |=> (trig_valid && $stable(trig_addr)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !dealloc) |=> overrun);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dealloc |=> (count == '0 && !trig_valid && !overrun));
endmodule

bind pend_ack_tracker pat_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc(alloc_i), .dealloc(dealloc_i),
  .msg_valid(msg_valid_i), .msg_count(msg_count_i), .active(slot_active),
  .count(pend_count_o), .trig_valid(trig_valid_o), .trig_ready(trig_ready_i),
  .trig_addr(trig_addr_o), .overrun(overrun_o)
);

// File: tb/sim_pend_ack_tracker.sv
module sim_pend_ack_tracker;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc = 1'b0, dealloc = 1'b0, mv = 1'b0, pop = 1'b0;
  logic [15:0]       aaddr = '0;
  logic signed [7:0] mcnt = '0;
  logic              tv, ovr;
  logic [15:0]       taddr;
  logic signed [7:0] pcnt;

  int checks = 0, failures = 0;
  bit fin = 0;

  // Bench model built from the requirements
  logic signed [7:0] m_cnt = '0;
  logic              m_act = 0, m_trig = 0, m_err = 0;
  logic [15:0]       m_addr = '0, m_taddr = '0;

  always #2 clk = ~clk;

  pend_ack_tracker #(.CNT_W(8), .ADDR_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .alloc_addr_i(aaddr),
    .dealloc_i(dealloc), .msg_valid_i(mv), .msg_count_i(mcnt),
    .trig_valid_o(tv), .trig_ready_i(pop), .trig_addr_o(taddr),
    .pend_count_o(pcnt), .overrun_o(ovr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic [15:0] ad, input logic d,
                      input logic v, input logic signed [7:0] c, input logic p,
                      input string tag);
    logic fire;
    @(negedge clk);
    alloc = a; aaddr = ad; dealloc = d; mv = v; mcnt = c; pop = p;
    @(posedge clk);
    fire = 0;
    if (d) begin
      m_act = 0; m_cnt = '0; m_trig = 0; m_err = 0;
    end else begin
      if (a) begin
        m_act = 1; m_cnt = '0; m_addr = ad;
      end else if (v && m_act) begin
        m_cnt = m_cnt - c;
        fire  = (m_cnt == 0);
      end
      if (fire) begin
        if (m_trig && !p) m_err = 1;
        m_trig = 1; m_taddr = m_addr;
      end else if (p) begin
        m_trig = 0;
      end
    end
    #1;
    chk(tag, "count", int'(pcnt), int'(m_cnt));
    chk(tag, "trig_valid", int'(tv), int'(m_trig));
    chk(tag, "overrun", int'(ovr), int'(m_err));
    if (m_trig) chk(tag, "trig_addr", int'(taddr), int'(m_taddr));
  endtask

  initial begin
    #(200000 * 4);
    if (!fin) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "count", int'(pcnt), 0);
    chk("R1", "trig_valid", int'(tv), 0);
    chk("R1", "overrun", int'(ovr), 0);
    @(negedge clk); rst_n = 1'b1;

    // R6: messages while the slot is closed
    step(0, 0, 0, 1, 8'sd5, 0, "R6");
    step(0, 0, 0, 1, 8'sd0, 0, "R6");

    // R3 R5 R10: every field value against a fresh slot
    for (int v = -128; v < 128; v++) begin
      step(1, 16'(v * 3 + 7), 0, 0, 0, 0, "R2");
      step(0, 0, 0, 1, 8'(v), 0, (v == -128) ? "R10" : ((v == 0) ? "R5" : "R3"));
      step(0, 0, 0, 0, 0, 1, "R7");
      step(0, 0, 1, 0, 0, 0, "R9");
    end

    // R4: data with +k then k plain acks
    for (int k = 1; k <= 6; k++) begin
      step(1, 16'(k + 16'h100), 0, 0, 0, 0, "R2");
      step(0, 0, 0, 1, 8'(k), 0, "R4");
      for (int j = 0; j < k; j++) step(0, 0, 0, 1, -8'sd1, 0, "R4");
      step(0, 0, 0, 0, 0, 1, "R7");
      step(0, 0, 1, 0, 0, 0, "R9");
    end

    // R4: acks first, data last
    step(1, 16'h0BEE, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, -8'sd1, 0, "R4");
    step(0, 0, 0, 1, -8'sd1, 0, "R4");
    step(0, 0, 0, 1, 8'sd2, 0, "R5");

    // R7: hold while ready low
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, "R7");

    // R8: post over an unconsumed trigger, then clear
    step(0, 0, 0, 1, 8'sd0, 0, "R8");
    step(0, 0, 0, 1, 8'sd0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 1, 0, 0, 0, "R9");
    // R8: post in the same cycle as a pop
    step(1, 16'h00AA, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 8'sd0, 0, "R8");
    step(0, 0, 0, 1, 8'sd0, 1, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");

    // R2: re-allocate mid transaction, message in same cycle ignored
    step(0, 0, 0, 1, 8'sd3, 0, "R3");
    step(1, 16'h1234, 0, 1, 8'sd9, 0, "R2");

    // R9: dealloc beats alloc and message
    step(0, 0, 0, 1, 8'sd4, 0, "R3");
    step(1, 16'h5555, 1, 1, 8'sd0, 0, "R9");
    step(0, 0, 0, 1, 8'sd2, 0, "R6");

    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule